// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block holds a word of `WIDTH` bits (eight by default) on a single rising-edge clock and, on each edge, does exactly one of four things: clear the word to zero, capture a parallel word, shift one place toward bit 0, or shift one place toward the top bit. A synchronous clear wins over everything else. A shift/load select comes next, and when it is low the direction input picks which way the word moves. A separate shift enable lets the word sit unchanged when neither clear nor load is asserted.

During a shift the serial input fills whichever end the shift has just emptied. The serial output is taken from the other end and is a pure combinational choice made by the current direction bit: bit 0 when the direction is right, the top bit when it is left. Every stage is also visible on the parallel output. To build longer chains, the serial output of one instance is wired to the serial input of the next outside the block. A power-on reset, asynchronous or synchronous by parameter, sets the word to zero.

Top module: `bidir_shift_reg`

## Requirements
- R1: While `rst_n` is low, and after it is released with no other edge-time action, `q_o` is all zeros.
- R2: When `clr_i` is 1 on a rising edge, `q_o` becomes all zeros, whatever the values of `load_i`, `shift_en_i`, `left_i`, `ser_i` and `d_i`.
- R3: When `clr_i` is 0 and `load_i` is 1 on a rising edge, `q_o` takes `d_i` (bit n of `d_i` goes to bit n), and `left_i` and `ser_i` have no effect.
- R4: When `clr_i`=0, `load_i`=0, `shift_en_i`=1 and `left_i`=0, the edge sets the top bit to `ser_i` and each bit n below it to the old bit n+1.
- R5: When `clr_i`=0, `load_i`=0, `shift_en_i`=1 and `left_i`=1, the edge sets bit 0 to `ser_i` and each bit n above it to the old bit n-1.
- R6: When `clr_i`=0, `load_i`=0 and `shift_en_i`=0, `q_o` keeps its value across the edge, whatever `left_i` and `ser_i` are.
- R7: A parallel load takes place with `shift_en_i` low as well as high.
- R8: `ser_o` equals bit 0 of `q_o` when `left_i` is 0 and the top bit of `q_o` when `left_i` is 1, and it follows a change of `left_i` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low power-on reset to zero |
| clr_i | input | 1 | Synchronous clear, highest priority |
| load_i | input | 1 | Shift/load select: 1 loads `d_i`, 0 shifts or holds |
| shift_en_i | input | 1 | Shift enable; 0 holds when not clearing or loading |
| left_i | input | 1 | Direction: 0 shifts toward bit 0, 1 toward the top bit; also picks the serial output tap |
| ser_i | input | 1 | Serial data entering the emptied end |
| d_i | input | WIDTH | Parallel load word |
| q_o | output | WIDTH | Current contents of all stages |
| ser_o | output | 1 | Serial data leaving the opposite end |

## Verification
All 256 words are loaded, and for each one the direction, serial input and shift enable are set to values that change with the word. This shows that a load ignores those three inputs and does not depend on the enable. Sixteen words with mixed bit patterns are each shifted through all eight places in each direction, with an alternating serial stream. A wrong neighbour, a wrong fill end or a swapped direction therefore shows up within one edge, and the serial output tap is checked on every step. Hold cycles switch direction and serial input without a clock enable, clears are applied together with load and with shift to show their priority, and a word with its two end bits unequal exposes the combinational tap switch.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   typedef enum logic [2:0] {
      OP_HOLD  = 3'd0,
      OP_CLEAR = 3'd1,
      OP_LOAD  = 3'd2,
      OP_SHR   = 3'd3,
      OP_SHL   = 3'd4
   } bsr_op_e;

endpackage

// File: rtl/bsr_op_decode.sv
module bsr_op_decode
   import bsr_pkg::*;
(
   input  logic    clr_i,
   input  logic    load_i,
   input  logic    shift_en_i,
   input  logic    left_i,
   output bsr_op_e op_o
);

   // clear > load > shift > hold
   always_comb begin
      if (clr_i)           op_o = OP_CLEAR;
      else if (load_i)     op_o = OP_LOAD;
      else if (shift_en_i) op_o = left_i ? OP_SHL : OP_SHR;
      else                 op_o = OP_HOLD;
   end

endmodule

// File: rtl/bsr_next.sv
module bsr_next
   import bsr_pkg::*;
#(
   parameter int WIDTH = 8
)(
   input  bsr_op_e          op_i,
   input  logic [WIDTH-1:0] q_i,
   input  logic [WIDTH-1:0] d_i,
   input  logic             ser_i,
   output logic [WIDTH-1:0] nxt_o
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic from_hi;
      logic from_lo;

      if (b == WIDTH - 1) begin : g_top
         assign from_hi = ser_i;
      end else begin : g_mid_hi
         assign from_hi = q_i[b+1];
      end

      if (b == 0) begin : g_bot
         assign from_lo = ser_i;
      end else begin : g_mid_lo
         assign from_lo = q_i[b-1];
      end

      always_comb begin
         unique case (op_i)
            OP_CLEAR: nxt_o[b] = 1'b0;
            OP_LOAD:  nxt_o[b] = d_i[b];
            OP_SHR:   nxt_o[b] = from_hi;
            OP_SHL:   nxt_o[b] = from_lo;
            default:  nxt_o[b] = q_i[b];
         endcase
      end
   end

endmodule

// File: rtl/bsr_tap.sv
module bsr_tap #(
   parameter int WIDTH = 8
)(
   input  logic [WIDTH-1:0] q_i,
   input  logic             left_i,
   output logic             ser_o
);

   localparam int TOP = WIDTH - 1;

   assign ser_o = left_i ? q_i[TOP] : q_i[0];

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
   import bsr_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit ASYNC_RESET = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             load_i,
   input  logic             shift_en_i,
   input  logic             left_i,
   input  logic             ser_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic             ser_o
);

   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("bidir_shift_reg: WIDTH must be at least 2");
   end

   bsr_op_e          op;
   logic [WIDTH-1:0] q_r;
   logic [WIDTH-1:0] q_nxt;

   bsr_op_decode u_dec (
      .clr_i      (clr_i),
      .load_i     (load_i),
      .shift_en_i (shift_en_i),
      .left_i     (left_i),
      .op_o       (op)
   );

   bsr_next #(.WIDTH(WIDTH)) u_next (
      .op_i  (op),
      .q_i   (q_r),
      .d_i   (d_i),
      .ser_i (ser_i),
      .nxt_o (q_nxt)
   );

   if (ASYNC_RESET) begin : g_arst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= q_nxt;
      end
   end else begin : g_srst
      always_ff @(posedge clk) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= q_nxt;
      end
   end

   bsr_tap #(.WIDTH(WIDTH)) u_tap (
      .q_i    (q_r),
      .left_i (left_i),
      .ser_o  (ser_o)
   );

   assign q_o = q_r;

   p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |=> (q_o == '0));

   p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (q_o == '0));

   p_load_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && load_i) |=> (q_o == $past(d_i)));

   p_shift_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !load_i && shift_en_i && !left_i)
      |=> (q_o == {$past(ser_i), $past(q_o[TOP:1])}));

   p_shift_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !load_i && shift_en_i && left_i)
      |=> (q_o == {$past(q_o[TOP-1:0]), $past(ser_i)}));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !load_i && !shift_en_i) |=> $stable(q_o));

   p_tap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ser_o == (left_i ? q_o[TOP] : q_o[0]));

endmodule

// File: tb/bidir_shift_reg_test.sv
module bidir_shift_reg_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clr_i = 1'b0;
   logic         load_i = 1'b0;
   logic         shift_en_i = 1'b0;
   logic         left_i = 1'b0;
   logic         ser_i = 1'b0;
   logic [W-1:0] d_i = '0;
   logic [W-1:0] q_o;
   logic         ser_o;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] exp_q = '0;

   always #2 clk = ~clk;

   bidir_shift_reg #(.WIDTH(W), .ASYNC_RESET(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .load_i(load_i),
      .shift_en_i(shift_en_i), .left_i(left_i), .ser_i(ser_i),
      .d_i(d_i), .q_o(q_o), .ser_o(ser_o)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected serial tap from the bench model
   function automatic logic tap(input logic [W-1:0] v, input logic lf);
      return lf ? v[W-1] : v[0];
   endfunction

   task automatic step(input string req, input logic c, input logic l, input logic e,
                       input logic lf, input logic s, input logic [W-1:0] d);
      @(negedge clk);
      clr_i = c; load_i = l; shift_en_i = e; left_i = lf; ser_i = s; d_i = d;
      if (c)       exp_q = '0;
      else if (l)  exp_q = d;
      else if (e && !lf) exp_q = (exp_q >> 1) | ({{(W-1){1'b0}}, s} << (W-1));
      else if (e)  exp_q = (exp_q << 1) | {{(W-1){1'b0}}, s};
      @(posedge clk);
      #1;
      chk(req, q_o, exp_q);
      chk({req, " R8 tap"}, {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, tap(exp_q, lf)});
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R1 during reset", q_o, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 after release", q_o, '0);

      // R3 / R7: every word, direction, serial and enable varied
      for (int v = 0; v < 256; v++) begin
         step("R3 R7 load", 1'b0, 1'b1, v[0], v[1], v[2], v[W-1:0]);
      end

      // R4 / R5: full passes each way
      for (int v = 3; v < 256; v += 16) begin
         step("R3 preload", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, v[W-1:0]);
         for (int k = 0; k < W; k++) begin
            step("R4 shift right", 1'b0, 1'b0, 1'b1, 1'b0, k[0] ^ v[4], 8'hFF);
         end
         step("R3 preload", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, v[W-1:0]);
         for (int k = 0; k < W; k++) begin
            step("R5 shift left", 1'b0, 1'b0, 1'b1, 1'b1, k[1] ^ v[5], 8'h00);
         end
      end

      // R6: hold while direction and serial input move
      step("R3 preload", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h96);
      for (int k = 0; k < 4; k++) begin
         step("R6 hold", 1'b0, 1'b0, 1'b0, k[0], k[1], 8'h3C);
      end

      // R2: clear beats load, shift and hold
      step("R2 clear over load", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF);
      step("R3 preload", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h7E);
      step("R2 clear over shift", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF);
      step("R3 preload", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h42);
      step("R2 clear over hold", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF);

      // R8: tap follows direction without a clock edge
      step("R3 preload", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80);
      @(negedge clk);
      load_i = 1'b0; shift_en_i = 1'b0;
      left_i = 1'b0;
      #0.5;
      chk("R8 tap right", {{(W-1){1'b0}}, ser_o}, '0);
      left_i = 1'b1;
      #0.5;
      chk("R8 tap left", {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, 1'b1});

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule